// File: doc/BRIEF.md
# Latched Safety Interlock Fault Controller

The block gathers the fault lines of a motion safety system: travel stops, emergency stops, a horizon stop, spares and the outputs of overspeed and overcurrent comparators. A slow sampling clock filters them, and every fault that gets through stays latched. A fault has to be present on a sample edge to move into the first stage of a two-register pipeline. One sample period later it sets a sticky global trip. A trip, or the board reset held low, forces every control output into a fixed safe state. In that state the active-low dome and telescope enables and the brake indicator go high, and the control-system enable goes low.

The slow clock is built inside the block from the system clock. It is a square wave whose period is set by parameters: the system clock frequency, and the sample period in microseconds. Each fault has a status flag. While the slow clock is high, the flag shows the fault input as it is. While the slow clock is low, the flag shows the value captured at the end of the high phase. A short glitch can therefore appear on a flag without tripping the board. A fault that has reached the first pipeline stage keeps its flag set until reset. A limit-override input masks a fixed set of axis-limit faults, which a parameter selects. The emergency stop, whose input reads high for run, is added as the topmost fault and cannot be masked. The active-low `rst_n` is both the board reset and the only way to clear latched faults.

Top module: `interlock_ctl`

## Requirements
- R1: The slow sample clock has a period of DIV = (CLK_HZ/1e6)*TICK_US system clocks. Its count restarts at 0 when reset is released. It is high while the count is below DIV/2, and its rising (sample) edge falls on the system clock edge that ends count DIV-1.
- R2: A fault that is present on a sample edge raises `trip` on the following sample edge. A fault that is absent at every sample edge never raises `trip`.
- R3: While the slow clock is high, `flt_flag[i]` follows effective fault i. While it is low, the flag holds the value the fault had at the edge that ends the high phase (count DIV/2-1).
- R4: While `ovr_on` is 1, the faults whose bits are set in OVR_MASK are ignored, both in the flags and in the trip path. Every other fault, and the emergency stop, cannot be masked.
- R5: Once `trip` is set it stays set until `rst_n` goes low. A fault that has been captured on a sample edge keeps its flag at 1 until `rst_n` goes low.
- R6: While `rst_n` is 0 or `trip` is 1, `dome_en_n`, `tel_en_n` and `brake_led` are 1 and `cs_en` is 0. `rst_n` low clears all flags and `trip` asynchronously.
- R7: The emergency stop input `estop_ok` is 1 for run and 0 for stop. It appears as fault bit NF of `flt_flag`. Each flag reads 1 for a fault and 0 for no fault.
- R8: With no trip and no reset, `dome_en_n` is 0 when `dome_sw` or `dome_hp` is 1, and 1 otherwise.
- R9: With no trip and no reset, `tel_en_n` and `brake_led` are 1 when `tel_sw` or `brake_en_in` is 0. Both are 0 when `tel_sw` and `brake_en_in` are both 1. `cs_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low board reset; clears latched faults |
| flt_raw | input | NF | Fault lines, 1 = fault (open switch or comparator trip) |
| estop_ok | input | 1 | Emergency stop, 1 = run, 0 = stop |
| ovr_on | input | 1 | Limit override, 1 = mask the OVR_MASK faults |
| tel_sw | input | 1 | Telescope enable switch, 1 = enable |
| brake_en_in | input | 1 | Brake release request, 1 = release |
| dome_sw | input | 1 | Dome software control request |
| dome_hp | input | 1 | Dome hand-paddle control request |
| flt_flag | output | NF+1 | Per-fault status, bit NF = emergency stop |
| trip | output | 1 | Latched global fault |
| dome_en_n | output | 1 | Active-low dome amplifier enable |
| tel_en_n | output | 1 | Active-low telescope amplifier and brake release enable |
| cs_en | output | 1 | Active-high control-system enable |
| brake_led | output | 1 | Brake indicator, 1 = brakes applied |

## Verification
The bench builds the block with CLK_HZ = 1 MHz and TICK_US = 10, which gives a ten-cycle slow clock with a five-cycle high phase. With NF = 8 and OVR_MASK = 8'h3C, masked and unmaskable faults sit side by side. A short period puts several sample edges within a few dozen cycles. Glitches can be placed inside the high phase, across the falling edge, and across a sample edge, so the filtering, the hold and the two-edge trip delay can all be reached in a short run.

// File: rtl/interlock_ctl.sv
module interlock_ctl #(
  parameter int NF       = 22,
  parameter int CLK_HZ   = 50_000_000,
  parameter int TICK_US  = 133_333,
  parameter logic [NF-1:0] OVR_MASK = 22'h3FF000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] flt_raw,
  input  logic          estop_ok,
  input  logic          ovr_on,
  input  logic          tel_sw,
  input  logic          brake_en_in,
  input  logic          dome_sw,
  input  logic          dome_hp,
  output logic [NF:0]   flt_flag,
  output logic          trip,
  output logic          dome_en_n,
  output logic          tel_en_n,
  output logic          cs_en,
  output logic          brake_led
);
  localparam int DIV  = (CLK_HZ / 1_000_000) * TICK_US;
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic [NF:0]   eff, s1, hold, frz;
  logic          trip_q, at_tick, at_fall, phase_hi, safe;

  assign eff      = {~estop_ok, flt_raw} & ~({1'b0, OVR_MASK} & {(NF+1){ovr_on}});
  assign at_tick  = (cnt == CW'(DIV - 1));
  assign at_fall  = (cnt == CW'(HALF - 1));
  assign phase_hi = (cnt < CW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      s1     <= '0;
      hold   <= '0;
      frz    <= '0;
      trip_q <= 1'b0;
    end else begin
      cnt <= at_tick ? '0 : cnt + 1'b1;
      if (at_fall) hold <= eff;
      if (at_tick) begin
        s1     <= eff;
        frz    <= frz | s1;
        trip_q <= trip_q | (|s1);
      end
    end
  end

  assign flt_flag  = frz | s1 | (phase_hi ? eff : hold);
  assign trip      = trip_q;
  assign safe      = ~rst_n | trip_q;
  assign dome_en_n = safe | ~(dome_sw | dome_hp);
  assign tel_en_n  = safe | ~(tel_sw & brake_en_in);
  assign brake_led = tel_en_n;
  assign cs_en     = ~safe;
endmodule

module interlock_ctl_chk #(
  parameter int NF = 22
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tel_sw,
  input logic        brake_en_in,
  input logic        dome_sw,
  input logic        dome_hp,
  input logic [NF:0] flt_flag,
  input logic        trip,
  input logic        dome_en_n,
  input logic        tel_en_n,
  input logic        cs_en,
  input logic        brake_led
);
  AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) trip |=> trip); // R5
  AST_SAFE_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    trip |-> (dome_en_n && tel_en_n && brake_led && !cs_en)); // R6
  AST_DOME_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && (dome_sw || dome_hp)) |-> !dome_en_n); // R8
  AST_TEL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!trip && tel_sw && brake_en_in) |-> (!tel_en_n && !brake_led && cs_en)); // R9
  AST_TEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tel_sw || !brake_en_in) |-> (tel_en_n && brake_led)); // R9
endmodule

bind interlock_ctl interlock_ctl_chk #(.NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .tel_sw(tel_sw), .brake_en_in(brake_en_in),
  .dome_sw(dome_sw), .dome_hp(dome_hp), .flt_flag(flt_flag), .trip(trip),
  .dome_en_n(dome_en_n), .tel_en_n(tel_en_n), .cs_en(cs_en), .brake_led(brake_led)
);

// File: tb/test_interlock_ctl.sv
module test_interlock_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam logic [NF-1:0] MASK = 8'h3C;
  localparam int DIV = 10;
  localparam int HALF = 5;

  logic clk = 0, rst_n = 0;
  logic [NF-1:0] flt_raw = '0;
  logic estop_ok = 1, ovr_on = 0, tel_sw = 0, brake_en_in = 0, dome_sw = 0, dome_hp = 0;
  logic [NF:0] flt_flag;
  logic trip, dome_en_n, tel_en_n, cs_en, brake_led;

  int checks = 0, errors = 0, cycles = 0;
  int m_cnt = 0;
  logic [NF:0] m_s1 = '0, m_hold = '0, m_frz = '0;
  logic m_trip = 0;

  interlock_ctl #(.NF(NF), .CLK_HZ(1_000_000), .TICK_US(10), .OVR_MASK(MASK)) i_interlock_ctl (
    .clk(clk), .rst_n(rst_n), .flt_raw(flt_raw), .estop_ok(estop_ok), .ovr_on(ovr_on),
    .tel_sw(tel_sw), .brake_en_in(brake_en_in), .dome_sw(dome_sw), .dome_hp(dome_hp),
    .flt_flag(flt_flag), .trip(trip), .dome_en_n(dome_en_n), .tel_en_n(tel_en_n),
    .cs_en(cs_en), .brake_led(brake_led));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; errors++;
        $display("FAIL watchdog act=%0d exp=<20000", cycles);
        summary();
      end
    end
  end

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [NF:0] eff_now();
    logic [NF:0] m = ovr_on ? {1'b0, MASK} : '0;
    return {~estop_ok, flt_raw} & ~m;
  endfunction

  function automatic logic [NF:0] exp_flag();
    return m_frz | m_s1 | ((m_cnt < HALF) ? eff_now() : m_hold);
  endfunction

  task automatic step();
    logic [NF:0] e;
    logic safe;
    @(posedge clk);
    e = eff_now();
    if (!rst_n) begin
      m_cnt = 0; m_s1 = '0; m_hold = '0; m_frz = '0; m_trip = 0;
    end else begin
      if (m_cnt == HALF - 1) m_hold = e;
      if (m_cnt == DIV - 1) begin
        if (m_s1 != 0) m_trip = 1;
        m_frz = m_frz | m_s1;
        m_s1 = e;
      end
      m_cnt = (m_cnt + 1) % DIV;
    end
    @(negedge clk);
    safe = !rst_n || m_trip;
    chk("R3 flags model", 64'(flt_flag), 64'(exp_flag()));
    chk("R2 trip model", 64'(trip), 64'(m_trip));
    chk("R6 outputs model", 64'({dome_en_n, tel_en_n, cs_en, brake_led}),
        64'({safe | ~(dome_sw | dome_hp), safe | ~(tel_sw & brake_en_in), ~safe,
             safe | ~(tel_sw & brake_en_in)}));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic to_cnt(int k);
    while (m_cnt != k) step();
  endtask

  task automatic do_reset();
    rst_n = 0; steps(2); rst_n = 1;
  endtask

  initial begin
    @(negedge clk);
    steps(2);
    chk("R6 reset cs_en", 64'(cs_en), 0);
    chk("R6 reset tel_en_n", 64'(tel_en_n), 1);
    chk("R6 reset flags", 64'(flt_flag), 0);
    rst_n = 1;
    tel_sw = 1; brake_en_in = 1;
    step();
    chk("R9 telescope enabled", 64'({tel_en_n, brake_led, cs_en}), 64'(3'b001));
    brake_en_in = 0; step();
    chk("R9 brake request low", 64'({tel_en_n, brake_led}), 64'(2'b11));
    brake_en_in = 1; dome_hp = 1; step();
    chk("R8 dome hand paddle", 64'(dome_en_n), 0);
    dome_hp = 0; step();
    chk("R8 dome idle", 64'(dome_en_n), 1);
    dome_sw = 1; step();
    chk("R8 dome software", 64'(dome_en_n), 0);

    // R1/R2: fault raised right after a sample edge trips on the second edge
    to_cnt(0);
    flt_raw[0] = 1;
    steps(9);
    chk("R1 count before edge", 64'(trip), 0);
    step();
    chk("R2 first edge no trip", 64'(trip), 0);
    steps(9);
    chk("R2 still no trip", 64'(trip), 0);
    step();
    chk("R2 trip on second edge", 64'(trip), 1);
    chk("R6 safe on trip", 64'({dome_en_n, tel_en_n, cs_en, brake_led}), 64'(4'b1101));
    flt_raw[0] = 0;
    steps(25);
    chk("R5 trip sticky", 64'(trip), 1);
    chk("R5 flag sticky", 64'(flt_flag[0]), 1);
    do_reset();
    step();
    chk("R6 reset clears", 64'({trip, flt_flag}), 0);

    // R3: glitch inside the high phase
    to_cnt(1);
    flt_raw[1] = 1; step();
    chk("R3 glitch visible", 64'(flt_flag[1]), 1);
    step(); flt_raw[1] = 0;
    to_cnt(6);
    chk("R3 glitch gone in low phase", 64'(flt_flag[1]), 0);
    // glitch across end of high phase
    to_cnt(3);
    flt_raw[1] = 1; to_cnt(6); flt_raw[1] = 0; step();
    chk("R3 held in low phase", 64'(flt_flag[1]), 1);
    to_cnt(1);
    chk("R3 released next high", 64'(flt_flag[1]), 0);
    steps(25);
    chk("R2 glitch no trip", 64'(trip), 0);

    // R4: masked fault ignored under override
    ovr_on = 1; flt_raw[2] = 1; flt_raw[5] = 1;
    steps(30);
    chk("R4 masked no trip", 64'(trip), 0);
    chk("R4 masked flags", 64'(flt_flag), 0);
    flt_raw[6] = 1; step();
    to_cnt(2);
    chk("R4 unmasked flag", 64'(flt_flag[6]), 1);
    steps(20);
    chk("R4 unmasked trips", 64'(trip), 1);
    flt_raw = '0; ovr_on = 0;
    do_reset();
    flt_raw[3] = 1; steps(25);
    chk("R4 no override trips", 64'(trip), 1);
    flt_raw = '0;
    do_reset();

    // R7: emergency stop polarity and not maskable
    ovr_on = 1;
    to_cnt(1);
    estop_ok = 0; step();
    chk("R7 estop flag", 64'(flt_flag[NF]), 1);
    steps(22);
    chk("R7 estop trips", 64'(trip), 1);
    estop_ok = 1; ovr_on = 0;
    do_reset();
    steps(25);
    chk("R7 run no trip", 64'(trip), 0);

    summary();
  end
endmodule